// File: doc/BRIEF.md
# I2C Master Write Engine with 10-bit Addressing

This block is a byte-oriented I2C master that only writes. Software drives it through three small registers: a control word, a status word and a one-byte data holding register. On the bus side it drives open-drain SCL and SDA lines. A transfer opens with a START condition. The first address byte follows, then the second address byte, then any number of data bytes, and a STOP condition closes it. The block samples the slave's acknowledge after every byte.

The data holding register and the output shift register form a double buffer. Once the first bit of a byte has been clocked onto the bus, the holding register reports empty again and the interrupt returns, so software can stage the next byte while the current one is still going out. If a byte completes with nothing staged and no STOP requested, the block holds SCL low until software acts. When a slave does not acknowledge, the block raises a flag and keeps the bus held. Software clears the condition by requesting STOP and flushing the holding register in a single control write.

The block does not form the address bytes. Software writes them as ordinary bytes. For a 10-bit write the first byte is `11110`, then address bits 9 and 8, then a 0 write bit. The second byte carries address bits 7 down to 0. Each half-period of SCL lasts `divHalf` system clocks.

Top module: `i2c10_wr_master`

## Requirements
- R1: After reset the status register (address 1) reads 0x01: bit 0 is the empty flag, bit 1 is ACK and bit 2 is the not-acknowledge flag. The irq output is low, and neither sclOe nor sdaOe drives its line.
- R2: irq is high when the enable bit (control bit 0) is set and either the transmit-interrupt enable (control bit 1) is set with the empty flag high, or the not-acknowledge flag is set. irq is low whenever enable is clear.
- R3: Writing control bit 2 (START) while enabled, with a byte staged, produces a START condition: SDA falls while SCL is high. START reads back as 0 once the condition has begun.
- R4: Each byte goes out most significant bit first, exactly as written to the data register (address 2). The 10-bit address bytes 11110·a9·a8·0 and a7..a0 need no special handling. SDA changes only while SCL is low, except during START and STOP.
- R5: When a byte is loaded into the shift register, the empty flag stays low until that byte's first bit has completed its SCL high period. The flag then rises, and with interrupts enabled irq rises with it.
- R6: When SDA is low at the end of the acknowledge clock's high period, the ACK status bit is set.
- R7: When SDA is high at that point, the not-acknowledge flag is set and ACK is cleared. No further byte is sent, and SCL stays low until STOP is requested.
- R8: Writing STOP (control bit 3) and FLUSH (control bit 4) together after a not-acknowledge produces a STOP condition (SDA rises while SCL is high). It clears the not-acknowledge flag and the STOP bit, and the staged byte is discarded without being sent.
- R9: FLUSH on its own discards a staged byte and sets the empty flag. A following START request then produces no bus activity.
- R10: If a byte is acknowledged while no byte is staged and STOP is not set, SCL is held low and no further bits are sent.
- R11: Every SCL high period of a data or acknowledge bit lasts exactly divHalf system clocks.
- R12: Setting STOP while SCL is held after an acknowledged byte produces a STOP condition and leaves both lines released, with STOP reading back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divHalf | input | DIV_W | System clocks per SCL half-period (at least 2) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWrData | input | BYTE_W | Register write data |
| regRdData | output | BYTE_W | Register read data for regAddr (combinational) |
| irq | output | 1 | Interrupt request |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| sdaIn | input | 1 | Sampled SDA line level |

## Verification
The assertions assume that divHalf is at least 2 and stays constant while a transfer is in progress. They also assume that software does not write the control register in the same cycle that a STOP completes, since a control write takes priority over the clearing of STOP. The bench changes divHalf only while the bus is idle and uses values of 4 and 6. Its modelled slave drives SDA only during the acknowledge clock, and the bench issues control writes only while the bus is held or idle, so both assumptions hold throughout the stimulus.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_TXIE  = 1;
  localparam int CTRL_START = 2;
  localparam int CTRL_STOP  = 3;
  localparam int CTRL_FLUSH = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START1,
    ST_START2,
    ST_BITLO,
    ST_BITHI,
    ST_ACKLO,
    ST_ACKHI,
    ST_WAIT,
    ST_PRESTOP,
    ST_STOP1,
    ST_STOP2
  } busState_t;

  typedef struct packed {
    logic loadShift;
    logic shiftBit;
    logic firstBitDone;
    logic setAck;
    logic setNack;
    logic busDone;
    logic clrStart;
  } ctlStrobe_t;

endpackage

// File: rtl/i2c10_dp.sv
module i2c10_dp
  import i2c10_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              irq,
  input  ctlStrobe_t        strb,
  output logic              enable,
  output logic              startReq,
  output logic              stopReq,
  output logic              dataFull,
  output logic              nackFlag,
  output logic              shiftMsb
);

  logic              txIeReg;
  logic              ackFlag;
  logic              firstPending;
  logic              emptyFlag;
  logic [BYTE_W-1:0] dataReg;
  logic [BYTE_W-1:0] shiftReg;
  logic              ctrlWr;
  logic              dataWr;

  assign ctrlWr    = regWrEn && (regAddr == REG_CTRL);
  assign dataWr    = regWrEn && (regAddr == REG_DATA);
  assign emptyFlag = !dataFull && !firstPending;
  assign shiftMsb  = shiftReg[BYTE_W-1];
  assign irq       = enable && ((txIeReg && emptyFlag) || nackFlag);

  // control bits; a software write wins over controller clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      txIeReg  <= 1'b0;
      startReq <= 1'b0;
      stopReq  <= 1'b0;
    end else if (ctrlWr) begin
      enable   <= regWrData[CTRL_EN];
      txIeReg  <= regWrData[CTRL_TXIE];
      startReq <= regWrData[CTRL_START];
      stopReq  <= regWrData[CTRL_STOP];
    end else begin
      if (strb.clrStart) startReq <= 1'b0;
      if (strb.busDone)  stopReq  <= 1'b0;
    end
  end

  // holding register and shift register form the double buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg      <= '0;
      dataFull     <= 1'b0;
      shiftReg     <= '0;
      firstPending <= 1'b0;
    end else begin
      if (ctrlWr && regWrData[CTRL_FLUSH]) begin
        dataFull <= 1'b0;
      end else if (dataWr) begin
        dataReg  <= regWrData;
        dataFull <= 1'b1;
      end else if (strb.loadShift) begin
        dataFull <= 1'b0;
      end

      if (strb.loadShift) begin
        shiftReg     <= dataReg;
        firstPending <= 1'b1;
      end else begin
        if (strb.shiftBit)     shiftReg     <= {shiftReg[BYTE_W-2:0], 1'b0};
        if (strb.firstBitDone) firstPending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackFlag  <= 1'b0;
      nackFlag <= 1'b0;
    end else begin
      if (strb.setAck) ackFlag <= 1'b1;
      if (strb.setNack) begin
        ackFlag  <= 1'b0;
        nackFlag <= 1'b1;
      end else if (strb.busDone) begin
        nackFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: begin
        regRdData[CTRL_EN]    = enable;
        regRdData[CTRL_TXIE]  = txIeReg;
        regRdData[CTRL_START] = startReq;
        regRdData[CTRL_STOP]  = stopReq;
      end
      REG_STAT: begin
        regRdData[0] = emptyFlag;
        regRdData[1] = ackFlag;
        regRdData[2] = nackFlag;
      end
      REG_DATA: regRdData = dataReg;
      default:  regRdData = '0;
    endcase
  end

  assert_ack_nack_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ackFlag && nackFlag));

  assert_load_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadShift |-> dataFull);

  assert_nack_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.busDone && !ctrlWr) |=> (!nackFlag && !stopReq));

endmodule

// File: rtl/i2c10_ctl.sv
module i2c10_ctl
  import i2c10_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             enable,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic             dataFull,
  input  logic             nackFlag,
  input  logic             shiftMsb,
  input  logic             sdaIn,
  output ctlStrobe_t       strb,
  output logic             sclOe,
  output logic             sdaOe
);

  localparam int BIT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  busState_t        state, stateNext;
  logic [DIV_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             tick;
  logic             sdaWant;
  logic             lineCtl;
  logic             dataPhase;

  assign tick = (phaseCnt == divHalf - 1'b1);

  always_comb begin
    sclOe = state inside {ST_START2, ST_BITLO, ST_ACKLO, ST_WAIT, ST_PRESTOP};
    lineCtl   = state inside {ST_IDLE, ST_START1, ST_STOP1, ST_STOP2};
    dataPhase = state inside {ST_BITLO, ST_BITHI, ST_ACKLO, ST_ACKHI, ST_WAIT};
    case (state)
      ST_START1, ST_START2, ST_PRESTOP, ST_STOP1: sdaWant = 1'b1;
      ST_BITLO, ST_BITHI:                         sdaWant = !shiftMsb;
      default:                                    sdaWant = 1'b0;
    endcase
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE:
        if (enable && startReq && dataFull) begin
          stateNext     = ST_START1;
          strb.clrStart = 1'b1;
        end
      ST_START1: if (tick) stateNext = ST_START2;
      ST_START2:
        if (tick) begin
          strb.loadShift = 1'b1;
          stateNext      = ST_BITLO;
        end
      ST_BITLO: if (tick) stateNext = ST_BITHI;
      ST_BITHI:
        if (tick) begin
          strb.shiftBit     = 1'b1;
          strb.firstBitDone = (bitCnt == '0);
          stateNext         = (bitCnt == BIT_LAST) ? ST_ACKLO : ST_BITLO;
        end
      ST_ACKLO: if (tick) stateNext = ST_ACKHI;
      ST_ACKHI:
        if (tick) begin
          strb.setAck  = !sdaIn;
          strb.setNack = sdaIn;
          stateNext    = ST_WAIT;
        end
      ST_WAIT:
        if (tick) begin
          if (stopReq) begin
            stateNext = ST_PRESTOP;
          end else if (!nackFlag && dataFull) begin
            strb.loadShift = 1'b1;
            stateNext      = ST_BITLO;
          end
        end
      ST_PRESTOP: if (tick) stateNext = ST_STOP1;
      ST_STOP1:   if (tick) stateNext = ST_STOP2;
      ST_STOP2:
        if (tick) begin
          strb.busDone = 1'b1;
          stateNext    = ST_IDLE;
        end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      sdaOe    <= 1'b0;
    end else begin
      state <= stateNext;
      if (stateNext != state || tick || state == ST_IDLE) phaseCnt <= '0;
      else                                                 phaseCnt <= phaseCnt + 1'b1;
      if (strb.loadShift)     bitCnt <= '0;
      else if (strb.shiftBit) bitCnt <= bitCnt + 1'b1;
      // data moves on SDA only while SCL is already low; START/STOP states move it with SCL high
      if (sclOe || lineCtl) sdaOe <= sdaWant;
    end
  end

  assert_sda_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dataPhase) && (sdaOe != $past(sdaOe))) |-> $past(sclOe));

  assert_start_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdaOe) && !sclOe) |-> (state == ST_START1));

  assert_stop_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sdaOe) && !sclOe) |-> (state == ST_STOP2));

  assert_div_min_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (divHalf >= 2));

endmodule

// File: rtl/i2c10_wr_master.sv
module i2c10_wr_master
  import i2c10_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              irq,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              sdaIn
);

  ctlStrobe_t strb;
  logic enable, startReq, stopReq, dataFull, nackFlag, shiftMsb;

  i2c10_dp #(.BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq), .strb(strb),
    .enable(enable), .startReq(startReq), .stopReq(stopReq),
    .dataFull(dataFull), .nackFlag(nackFlag), .shiftMsb(shiftMsb)
  );

  i2c10_ctl #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .divHalf(divHalf),
    .enable(enable), .startReq(startReq), .stopReq(stopReq),
    .dataFull(dataFull), .nackFlag(nackFlag), .shiftMsb(shiftMsb),
    .sdaIn(sdaIn), .strb(strb), .sclOe(sclOe), .sdaOe(sdaOe)
  );

endmodule

// File: tb/test_i2c10_wr_master.sv
module test_i2c10_wr_master;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [DIV_W-1:0] divHalf = 8'd4;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic irq, sclOe, sdaOe;
  logic slaveLow;
  logic sclLine, sdaLine;

  assign sclLine = !sclOe;
  assign sdaLine = !(sdaOe || slaveLow);

  i2c10_wr_master #(.DIV_W(DIV_W), .BYTE_W(8)) i_i2c10_wr_master (
    .clk(clk), .rst_n(rst_n), .divHalf(divHalf),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq), .sclOe(sclOe), .sdaOe(sdaOe),
    .sdaIn(sdaLine)
  );

  int checks = 0;
  int errors = 0;

  // bus monitor and acknowledging slave model
  logic prevScl, prevSda;
  logic [7:0] shiftIn;
  logic [7:0] rxBytes [0:15];
  int bitIdx = 0, startCnt = 0, stopCnt = 0, rxCount = 0;
  int byteInFrame = 0, nackAt = -1, hiRun = 0, lastHiLen = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prevScl = 1'b1; prevSda = 1'b1; slaveLow = 1'b0; shiftIn = 8'd0;
    end else begin
      if (sclLine) hiRun = prevScl ? hiRun + 1 : 1;
      if (prevScl && sclLine && prevSda && !sdaLine) begin
        startCnt++; bitIdx = 0; byteInFrame = 0;
      end else if (prevScl && sclLine && !prevSda && sdaLine) begin
        stopCnt++;
      end
      if (!prevScl && sclLine) begin
        shiftIn = {shiftIn[6:0], sdaLine};
        bitIdx++;
        if (bitIdx == 8) begin
          if (rxCount < 16) rxBytes[rxCount] = shiftIn;
          rxCount++;
        end
      end
      if (prevScl && !sclLine) begin
        if (bitIdx >= 1 && bitIdx <= 9) lastHiLen = hiRun;
        if (bitIdx == 8) begin
          slaveLow = (byteInFrame != nackAt);
          byteInFrame++;
        end else if (bitIdx == 9) begin
          slaveLow = 1'b0;
          bitIdx = 0;
        end
      end
      prevScl = sclLine;
      prevSda = sdaLine;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIrq();
    @(negedge clk);
    while (!irq) @(negedge clk);
    #1;
  endtask

  task automatic testReset();
    logic [7:0] v;
    rdReg(2'd1, v);
    chk(v == 8'h01, "R1 status after reset", v, 8'h01);
    chk(!irq && !sclOe && !sdaOe, "R1 irq and lines idle", {irq, sclOe, sdaOe}, 0);
    wrReg(2'd0, 8'h02);
    chk(!irq, "R2 irq low while disabled", irq, 0);
    wrReg(2'd0, 8'h03);
    chk(irq, "R2 irq when enabled and empty", irq, 1);
  endtask

  task automatic testWrite();
    logic [7:0] v;
    int base;
    base = rxCount;
    divHalf = 8'd4;
    nackAt = -1;
    wrReg(2'd2, 8'hF2);
    rdReg(2'd1, v);
    chk(v[0] == 1'b0 && !irq, "R2 irq drops once a byte is staged", {v[0], irq}, 0);
    wrReg(2'd0, 8'h07);
    waitIrq();
    chk(startCnt == 1, "R3 START condition seen", startCnt, 1);
    chk(bitIdx == 1, "R5 refill irq after first bit", bitIdx, 1);
    rdReg(2'd0, v);
    chk(v[2] == 1'b0, "R3 START bit self-clears", v[2], 0);
    wrReg(2'd2, 8'h5A);
    waitIrq();
    chk(bitIdx == 1, "R5 refill irq on second byte", bitIdx, 1);
    chk(rxBytes[base] == 8'hF2, "R4 first address byte", rxBytes[base], 8'hF2);
    rdReg(2'd1, v);
    chk(v[1] == 1'b1, "R6 ACK set after acknowledged byte", v[1], 1);
    wrReg(2'd2, 8'hC3);
    waitIrq();
    chk(rxBytes[base+1] == 8'h5A, "R4 second address byte", rxBytes[base+1], 8'h5A);
    wrReg(2'd2, 8'h01);
    waitIrq();
    chk(rxBytes[base+2] == 8'hC3, "R4 data byte MSB first", rxBytes[base+2], 8'hC3);
    while (!(rxCount == base + 4 && bitIdx == 0)) @(negedge clk);
    waitCycles(12 * 4);
    chk(sclOe == 1'b1, "R10 SCL held low when empty", sclOe, 1);
    chk(rxCount == base + 4 && bitIdx == 0, "R10 no extra bits while held", rxCount - base, 4);
    chk(rxBytes[base+3] == 8'h01, "R4 last data byte", rxBytes[base+3], 8'h01);
    chk(lastHiLen == 4, "R11 SCL high period at divider 4", lastHiLen, 4);
    wrReg(2'd0, 8'h0B);
    while (stopCnt < 1) @(negedge clk);
    waitCycles(4);
    chk(stopCnt == 1, "R12 STOP condition seen", stopCnt, 1);
    rdReg(2'd0, v);
    chk(v[3] == 1'b0, "R12 STOP bit self-clears", v[3], 0);
    chk(!sclOe && !sdaOe, "R12 lines released", {sclOe, sdaOe}, 0);
  endtask

  task automatic testNack();
    logic [7:0] v;
    int base;
    base = rxCount;
    divHalf = 8'd6;
    nackAt = 1;
    wrReg(2'd2, 8'hF6);
    wrReg(2'd0, 8'h07);
    waitIrq();
    wrReg(2'd2, 8'h33);
    waitIrq();
    wrReg(2'd2, 8'h77);
    v = 8'h00;
    while (!v[2]) rdReg(2'd1, v);
    chk(v[1] == 1'b0, "R7 ACK cleared on not-acknowledge", v[1], 0);
    chk(irq == 1'b1, "R2 irq from not-acknowledge flag", irq, 1);
    waitCycles(10 * 6);
    chk(sclOe == 1'b1, "R7 SCL held low after not-acknowledge", sclOe, 1);
    chk(rxCount == base + 2, "R7 no byte after not-acknowledge", rxCount - base, 2);
    chk(lastHiLen == 6, "R11 SCL high period at divider 6", lastHiLen, 6);
    wrReg(2'd0, 8'h19);
    while (stopCnt < 2) @(negedge clk);
    waitCycles(20);
    rdReg(2'd1, v);
    chk(v == 8'h01, "R8 status after STOP and FLUSH", v, 8'h01);
    rdReg(2'd0, v);
    chk(v[3] == 1'b0, "R8 STOP bit cleared", v[3], 0);
    chk(!irq, "R8 irq low after recovery", irq, 0);
    chk(rxCount == base + 2, "R8 flushed byte never sent", rxCount - base, 2);
    chk(rxBytes[base+1] == 8'h33, "R4 second byte before not-acknowledge", rxBytes[base+1], 8'h33);
  endtask

  task automatic testFlush();
    logic [7:0] v;
    int s;
    s = startCnt;
    wrReg(2'd0, 8'h01);
    wrReg(2'd2, 8'h3C);
    rdReg(2'd1, v);
    chk(v[0] == 1'b0, "R9 empty low with byte staged", v[0], 0);
    wrReg(2'd0, 8'h11);
    rdReg(2'd1, v);
    chk(v[0] == 1'b1, "R9 FLUSH sets empty", v[0], 1);
    wrReg(2'd0, 8'h05);
    waitCycles(60);
    chk(startCnt == s && !sclOe && !sdaOe, "R9 no START after flushed byte", startCnt - s, 0);
    wrReg(2'd0, 8'h01);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCycles(4);
    rst_n = 1'b1;
    waitCycles(2);
    testReset();
    testWrite();
    testNack();
    testFlush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule